// File: doc/BRIEF.md
# Security-Banked Interrupt Interface Register File

This block is the per-processor register file of an interrupt controller's processor interface. It stores a priority mask, three binary-point values, four active-priority words per interrupt group, one enable bit per group and the writable bits of two banked control words. A single access port carries a register select, a read/write strobe, write data and the processor context. That context is the security state, the exception level, whether EL3 exists, whether the processor runs in its highest mode, whether FIQ is routed to EL3, and the distributor's security-disable bit.

The context steers every access. It picks the secure or non-secure bank of each banked register. It gives non-secure software a shifted and clipped view of the shared priority mask. It can send a group-1 binary-point access to the group-0 copy. Read data is registered and appears one cycle after a read strobe. After every write the register file accepts, it raises a one-cycle update pulse so the prioritisation logic can re-evaluate.

Top module: `irq_cpuif_regs`

## Requirements
- R1: On reset, the following read as 0: the priority mask, all twelve active-priority words and the three enables. Both control banks read 0x8F00. This value has bit 15 set, bits 13:11 = 1 and bits 10:8 = 7. The group-0 and secure group-1 binary points reset to BP_RST. The non-secure group-1 binary point resets to BP_RST_NS when ctx_has_el3_i is high, and to BP_RST otherwise. update_o is low.
- R2: Select 0 is the 8-bit priority mask. Outside the non-secure view, a write stores wdata[7:0] and a read returns the stored byte.
- R3: The non-secure view of select 0 applies when ctx_has_el3_i=1, ctx_secure_i=0 and ctx_fiq_el3_i=1. In this view, a stored byte with bit 7 clear reads 0. A stored 0xFF reads 0xFF. Any other stored byte reads as (stored<<1) truncated to 8 bits.
- R4: In the non-secure view, a write to select 0 is ignored while the stored bit 7 is clear. Otherwise it stores 0x80 | (wdata[7:0]>>1).
- R5: Select 1 is the group-0 binary point. Select 2 is group 1. An access is secure-banked when ctx_has_el3_i=1, ctx_secure_i=1 and ctx_el_i!=3; otherwise it is non-secure. Select 2 uses the secure group-1 copy for secure-banked accesses and the non-secure copy for the rest. Values are 3 bits wide, held in rdata[2:0].
- R6: A secure-banked select-2 access is redirected to the group-0 copy, for both read and write, when ctx_el3_mode_i=0 and the secure control bank's bit 0 is 1.
- R7: A non-secure select-2 access with ctx_el_i<3, while the non-secure control bank's bit 0 is 1, reads min(group-0 value + 1, 7). Writes made under this condition are ignored.
- R8: Selects 8-11 are group-0 active-priority words 0-3. Selects 12-15 are the banked group-1 words 0-3, using the same banking as R5. All are 32 bits wide. A non-secure write to select 12 or 13 is ignored when ctx_has_el3_i=1.
- R9: Select 5 is the group-0 enable and select 6 is the banked group-1 enable, each in bit 0. Select 7 is an alias: bit 0 is the non-secure group-1 enable and bit 1 is the secure group-1 enable, for both reads and writes.
- R10: Select 3 is the banked control word. Bit 1 is the EOI mode and is always writable. Bit 0, the common binary point, is writable only when ctx_has_el3_i=0 or ctx_sec_dis_i=1. All other bits ignore writes.
- R11: rdata_o takes the selected value one cycle after a read strobe and holds its value at all other times. Select 4 is unused, reads 0 and ignores writes.
- R12: update_o is high for exactly the cycle after each accepted write. Reads, ignored writes and writes to select 4 leave it low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_valid_i | input | 1 | Access strobe |
| acc_write_i | input | 1 | 1 = write, 0 = read |
| acc_sel_i | input | 4 | Register select |
| acc_wdata_i | input | DATA_W | Write data |
| ctx_secure_i | input | 1 | Processor is in secure state |
| ctx_el_i | input | 2 | Current exception level |
| ctx_has_el3_i | input | 1 | EL3 is implemented |
| ctx_el3_mode_i | input | 1 | Processor is at EL3 or in monitor mode |
| ctx_fiq_el3_i | input | 1 | FIQ is routed to EL3 |
| ctx_sec_dis_i | input | 1 | Distributor security-disable bit |
| rdata_o | output | DATA_W | Registered read data |
| update_o | output | 1 | One-cycle pulse after an accepted write |

## Verification
The bench goes after the priority-mask view at its edges: a stored byte below 0x80, exactly 0xFF, and a non-secure write landing on a secure-range value. A design that got these wrong would leak secure priorities, wrap 0xFF to 0xFE, or let non-secure code lower the mask. It checks the binary-point redirection. It drives a group-0 value of 6 and confirms the +1 read saturates at 7. It also sends a secure write through the redirect, which a wrong design would store in the group-1 copy. It writes the protected active-priority words and the control word under each context, so a design that ignored the context would show a changed word or a changed common-binary-point bit. Random context and select sequences then compare every read and every update pulse against a bench model.

// File: rtl/irq_cpuif_pkg.sv
package irq_cpuif_pkg;
  localparam int SEL_W   = 4;
  localparam int NUM_GRP = 3;

  localparam logic [SEL_W-1:0] SEL_PMASK  = 4'd0;
  localparam logic [SEL_W-1:0] SEL_BP0    = 4'd1;
  localparam logic [SEL_W-1:0] SEL_BP1    = 4'd2;
  localparam logic [SEL_W-1:0] SEL_CTRL   = 4'd3;
  localparam logic [SEL_W-1:0] SEL_RSVD   = 4'd4;
  localparam logic [SEL_W-1:0] SEL_EN0    = 4'd5;
  localparam logic [SEL_W-1:0] SEL_EN1    = 4'd6;
  localparam logic [SEL_W-1:0] SEL_EN_ALS = 4'd7;

  localparam logic [1:0] GRP_G0   = 2'd0;
  localparam logic [1:0] GRP_G1S  = 2'd1;
  localparam logic [1:0] GRP_G1NS = 2'd2;

  localparam int CTRL_CBPR_BIT = 0;
  localparam int CTRL_EOI_BIT  = 1;
  // fixed fields: A3V bit 15, id-bits 13:11 = 1, prio-bits 10:8 = 7
  localparam logic [31:0] CTRL_CONST = 32'h0000_8F00;
endpackage

// File: rtl/irq_cpuif_pmr.sv
module irq_cpuif_pmr #(
  parameter int PRIO_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              ns_view_i,
  input  logic [PRIO_W-1:0] wdata_i,
  output logic [PRIO_W-1:0] val_o,
  output logic [PRIO_W-1:0] rd_o,
  output logic              accept_o
);
  localparam int MSB = PRIO_W - 1;
  localparam logic [PRIO_W-1:0] ALL1 = '1;
  localparam logic [PRIO_W-1:0] TOP1 = {1'b1, {(PRIO_W-1){1'b0}}};

  logic [PRIO_W-1:0] val_q, nxt;

  always_comb begin
    if (!ns_view_i)            rd_o = val_q;
    else if (!val_q[MSB])      rd_o = '0;
    else if (val_q == ALL1)    rd_o = ALL1;
    else                       rd_o = val_q << 1;
  end

  assign accept_o = we_i && !(ns_view_i && !val_q[MSB]);
  assign nxt      = ns_view_i ? (TOP1 | (wdata_i >> 1)) : wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       val_q <= '0;
    else if (accept_o) val_q <= nxt;
  end

  assign val_o = val_q;
endmodule

// File: rtl/irq_cpuif_bpr.sv
module irq_cpuif_bpr
  import irq_cpuif_pkg::*;
#(
  parameter int BP_W      = 3,
  parameter int BP_RST    = 0,
  parameter int BP_RST_NS = 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            has_el3_i,
  input  logic            we_i,
  input  logic            g1_i,
  input  logic            bank_s_i,
  input  logic            el3_mode_i,
  input  logic            below_el3_i,
  input  logic            cbpr_s_i,
  input  logic            cbpr_ns_i,
  input  logic [BP_W-1:0] wdata_i,
  output logic [BP_W-1:0] rd_o,
  output logic            accept_o
);
  localparam logic [BP_W-1:0] BP_MAX = '1;
  localparam logic [BP_W-1:0] RST_V  = BP_W'(BP_RST);
  localparam logic [BP_W-1:0] RST_NS = BP_W'(BP_RST_NS);

  logic [BP_W-1:0] bp_q [NUM_GRP];
  logic [1:0]      tgt;
  logic            satinc;

  always_comb begin
    tgt    = GRP_G0;
    satinc = 1'b0;
    if (g1_i) tgt = bank_s_i ? GRP_G1S : GRP_G1NS;
    if (tgt == GRP_G1S && !el3_mode_i && cbpr_s_i) tgt = GRP_G0;
    if (tgt == GRP_G1NS && below_el3_i && cbpr_ns_i) begin
      tgt    = GRP_G0;
      satinc = 1'b1;
    end
  end

  assign rd_o     = satinc ? ((bp_q[0] == BP_MAX) ? BP_MAX : bp_q[0] + 1'b1)
                           : bp_q[tgt];
  assign accept_o = we_i && !satinc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bp_q[0] <= RST_V;
      bp_q[1] <= RST_V;
      bp_q[2] <= has_el3_i ? RST_NS : RST_V;
    end else if (accept_o) begin
      bp_q[tgt] <= wdata_i;
    end
  end
endmodule

// File: rtl/irq_cpuif_apr.sv
module irq_cpuif_apr
  import irq_cpuif_pkg::*;
#(
  parameter int NUM_WORDS  = 4,
  parameter int WORD_W     = 32,
  parameter int PROT_WORDS = 2,
  localparam int IDX_W     = $clog2(NUM_WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              has_el3_i,
  input  logic              we_i,
  input  logic [1:0]        grp_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] rd_o,
  output logic              accept_o
);
  logic [WORD_W-1:0] words [NUM_GRP*NUM_WORDS];

  // non-secure may not claim activity at secure priorities
  assign accept_o = we_i && !(grp_i == GRP_G1NS && has_el3_i &&
                              32'(idx_i) < PROT_WORDS);

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
      logic [WORD_W-1:0] word_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) word_q <= '0;
        else if (accept_o && grp_i == 2'(g) && idx_i == IDX_W'(w))
          word_q <= wdata_i;
      end
      assign words[g*NUM_WORDS+w] = word_q;
    end
  end

  assign rd_o = words[int'(grp_i)*NUM_WORDS + int'(idx_i)];
endmodule

// File: rtl/irq_cpuif_regs.sv
module irq_cpuif_regs
  import irq_cpuif_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int PRIO_W    = 8,
  parameter int BP_W      = 3,
  parameter int BP_RST    = 0,
  parameter int BP_RST_NS = 1,
  parameter int AP_WORDS  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_valid_i,
  input  logic              acc_write_i,
  input  logic [SEL_W-1:0]  acc_sel_i,
  input  logic [DATA_W-1:0] acc_wdata_i,
  input  logic              ctx_secure_i,
  input  logic [1:0]        ctx_el_i,
  input  logic              ctx_has_el3_i,
  input  logic              ctx_el3_mode_i,
  input  logic              ctx_fiq_el3_i,
  input  logic              ctx_sec_dis_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              update_o
);
  localparam int IDX_W = $clog2(AP_WORDS);

  logic wr, rd, bank_s, below_el3, ns_view, ctrl_b, cbpr_wr_ok;
  logic pmr_acc, bp_acc, ap_acc, wr_acc;
  logic [PRIO_W-1:0] pmr_val, pmr_rd;
  logic [BP_W-1:0]   bp_rd;
  logic [DATA_W-1:0] ap_rd, rview;
  logic [1:0]        ap_grp, en_grp;
  logic [1:0]        cbpr_q, eoi_q;  // index 0 secure bank, 1 non-secure bank
  logic [2:0]        en_q;

  assign wr         = acc_valid_i && acc_write_i;
  assign rd         = acc_valid_i && !acc_write_i;
  assign below_el3  = ctx_el_i != 2'd3;
  assign bank_s     = ctx_has_el3_i && ctx_secure_i && below_el3;
  assign ns_view    = ctx_has_el3_i && !ctx_secure_i && ctx_fiq_el3_i;
  assign ctrl_b     = !bank_s;
  assign cbpr_wr_ok = !ctx_has_el3_i || ctx_sec_dis_i;
  assign en_grp     = bank_s ? GRP_G1S : GRP_G1NS;
  assign ap_grp     = acc_sel_i[2] ? en_grp : GRP_G0;

  irq_cpuif_pmr #(.PRIO_W(PRIO_W)) u_pmr (
    .clk_i, .rst_ni,
    .we_i      (wr && acc_sel_i == SEL_PMASK),
    .ns_view_i (ns_view),
    .wdata_i   (acc_wdata_i[PRIO_W-1:0]),
    .val_o     (pmr_val),
    .rd_o      (pmr_rd),
    .accept_o  (pmr_acc)
  );

  irq_cpuif_bpr #(.BP_W(BP_W), .BP_RST(BP_RST), .BP_RST_NS(BP_RST_NS)) u_bpr (
    .clk_i, .rst_ni,
    .has_el3_i   (ctx_has_el3_i),
    .we_i        (wr && (acc_sel_i == SEL_BP0 || acc_sel_i == SEL_BP1)),
    .g1_i        (acc_sel_i == SEL_BP1),
    .bank_s_i    (bank_s),
    .el3_mode_i  (ctx_el3_mode_i),
    .below_el3_i (below_el3),
    .cbpr_s_i    (cbpr_q[0]),
    .cbpr_ns_i   (cbpr_q[1]),
    .wdata_i     (acc_wdata_i[BP_W-1:0]),
    .rd_o        (bp_rd),
    .accept_o    (bp_acc)
  );

  irq_cpuif_apr #(.NUM_WORDS(AP_WORDS), .WORD_W(DATA_W)) u_apr (
    .clk_i, .rst_ni,
    .has_el3_i (ctx_has_el3_i),
    .we_i      (wr && acc_sel_i[3]),
    .grp_i     (ap_grp),
    .idx_i     (acc_sel_i[IDX_W-1:0]),
    .wdata_i   (acc_wdata_i),
    .rd_o      (ap_rd),
    .accept_o  (ap_acc)
  );

  always_comb begin
    rview  = '0;
    wr_acc = 1'b0;
    if (acc_sel_i[3]) begin
      rview  = ap_rd;
      wr_acc = ap_acc;
    end else begin
      case (acc_sel_i)
        SEL_PMASK:  begin rview = DATA_W'(pmr_rd);  wr_acc = pmr_acc; end
        SEL_BP0,
        SEL_BP1:    begin rview = DATA_W'(bp_rd);   wr_acc = bp_acc;  end
        SEL_CTRL:   begin
          rview = DATA_W'(CTRL_CONST);
          rview[CTRL_CBPR_BIT] = cbpr_q[ctrl_b];
          rview[CTRL_EOI_BIT]  = eoi_q[ctrl_b];
          wr_acc = wr;
        end
        SEL_EN0:    begin rview = DATA_W'(en_q[0]);             wr_acc = wr; end
        SEL_EN1:    begin rview = DATA_W'(en_q[en_grp]);        wr_acc = wr; end
        SEL_EN_ALS: begin rview = DATA_W'({en_q[1], en_q[2]});  wr_acc = wr; end
        default:    begin rview = '0;                           wr_acc = 1'b0; end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cbpr_q <= '0;
      eoi_q  <= '0;
      en_q   <= '0;
    end else if (wr) begin
      case (acc_sel_i)
        SEL_CTRL: begin
          eoi_q[ctrl_b] <= acc_wdata_i[CTRL_EOI_BIT];
          if (cbpr_wr_ok) cbpr_q[ctrl_b] <= acc_wdata_i[CTRL_CBPR_BIT];
        end
        SEL_EN0:    en_q[0]      <= acc_wdata_i[0];
        SEL_EN1:    en_q[en_grp] <= acc_wdata_i[0];
        SEL_EN_ALS: begin
          en_q[2] <= acc_wdata_i[0];
          en_q[1] <= acc_wdata_i[1];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o  <= '0;
      update_o <= 1'b0;
    end else begin
      update_o <= wr_acc;
      if (rd) rdata_o <= rview;
    end
  end
endmodule

// File: rtl/irq_cpuif_regs_chk.sv
module irq_cpuif_regs_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              acc_valid_i,
  input logic              acc_write_i,
  input logic [3:0]        acc_sel_i,
  input logic [DATA_W-1:0] acc_wdata_i,
  input logic              ctx_secure_i,
  input logic [1:0]        ctx_el_i,
  input logic              ctx_has_el3_i,
  input logic              ctx_fiq_el3_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              update_o,
  input logic [7:0]        pmr_val,
  input logic [2:0]        en_q
);
  logic c_wr, c_rd, c_nsv, c_bank_s;
  assign c_wr     = acc_valid_i && acc_write_i;
  assign c_rd     = acc_valid_i && !acc_write_i;
  assign c_nsv    = ctx_has_el3_i && !ctx_secure_i && ctx_fiq_el3_i;
  assign c_bank_s = ctx_has_el3_i && ctx_secure_i && (ctx_el_i != 2'd3);

  assert_upd_src_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    update_o |-> $past(c_wr));

  assert_rd_no_upd_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    c_rd |=> !update_o);

  assert_rdata_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !c_rd |=> $stable(rdata_o));

  assert_pmr_guard_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (c_wr && acc_sel_i == 4'd0 && c_nsv && !pmr_val[7]) |=> $stable(pmr_val));

  assert_ap_guard_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (c_wr && acc_sel_i[3:2] == 2'b11 && !acc_sel_i[1] && !c_bank_s && ctx_has_el3_i)
    |=> !update_o);

  assert_alias_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (c_wr && acc_sel_i == 4'd7) |=>
    (en_q[2] == $past(acc_wdata_i[0]) && en_q[1] == $past(acc_wdata_i[1])));
endmodule

bind irq_cpuif_regs irq_cpuif_regs_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .acc_valid_i   (acc_valid_i),
  .acc_write_i   (acc_write_i),
  .acc_sel_i     (acc_sel_i),
  .acc_wdata_i   (acc_wdata_i),
  .ctx_secure_i  (ctx_secure_i),
  .ctx_el_i      (ctx_el_i),
  .ctx_has_el3_i (ctx_has_el3_i),
  .ctx_fiq_el3_i (ctx_fiq_el3_i),
  .rdata_o       (rdata_o),
  .update_o      (update_o),
  .pmr_val       (pmr_val),
  .en_q          (en_q)
);

// File: tb/irq_cpuif_regs_tb.sv
`timescale 1ns/1ps
module irq_cpuif_regs_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0, write = 1'b0;
  logic [3:0]  sel = '0;
  logic [31:0] wdata = '0;
  logic        c_sec = 1'b1, c_has3 = 1'b1, c_mon = 1'b0, c_fiq = 1'b0, c_sdis = 1'b0;
  logic [1:0]  c_el = 2'd1;
  logic [31:0] rdata;
  logic        update;
  int          n_chk = 0, n_err = 0;

  // bench model state
  logic [7:0]  m_pmr;
  logic [2:0]  m_bp [3];
  logic [31:0] m_ap [3][4];
  logic        m_en [3];
  logic        m_cbpr [2];
  logic        m_eoi [2];

  always #4 clk = ~clk;

  irq_cpuif_regs u_dut (
    .clk_i(clk), .rst_ni(rst_n), .acc_valid_i(valid), .acc_write_i(write),
    .acc_sel_i(sel), .acc_wdata_i(wdata), .ctx_secure_i(c_sec), .ctx_el_i(c_el),
    .ctx_has_el3_i(c_has3), .ctx_el3_mode_i(c_mon), .ctx_fiq_el3_i(c_fiq),
    .ctx_sec_dis_i(c_sdis), .rdata_o(rdata), .update_o(update)
  );

  function automatic logic bs();
    return c_has3 && c_sec && (c_el != 2'd3);
  endfunction
  function automatic logic nsv();
    return c_has3 && !c_sec && c_fiq;
  endfunction

  // returns group index for select 2, sets sat when NS common-bp applies
  function automatic int bp1_grp(output logic sat);
    int g;
    sat = 1'b0;
    g = bs() ? 1 : 2;
    if (g == 1 && !c_mon && m_cbpr[0]) g = 0;
    if (g == 2 && c_el != 2'd3 && m_cbpr[1]) begin g = 0; sat = 1'b1; end
    return g;
  endfunction

  function automatic logic [31:0] m_read(logic [3:0] s);
    logic sat;
    int g;
    if (s[3]) begin
      g = s[2] ? (bs() ? 1 : 2) : 0;
      return m_ap[g][s[1:0]];
    end
    case (s)
      4'd0: begin
        if (!nsv()) return {24'h0, m_pmr};
        if (!m_pmr[7]) return 32'h0;
        if (m_pmr == 8'hFF) return 32'hFF;
        return {24'h0, m_pmr[6:0], 1'b0};
      end
      4'd1: return {29'h0, m_bp[0]};
      4'd2: begin
        g = bp1_grp(sat);
        if (sat) return (m_bp[0] == 3'd7) ? 32'd7 : {29'h0, m_bp[0] + 3'd1};
        return {29'h0, m_bp[g]};
      end
      4'd3: return 32'h8F00 | {30'h0, m_eoi[bs() ? 0 : 1], m_cbpr[bs() ? 0 : 1]};
      4'd5: return {31'h0, m_en[0]};
      4'd6: return {31'h0, m_en[bs() ? 1 : 2]};
      4'd7: return {30'h0, m_en[1], m_en[2]};
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic m_write(logic [3:0] s, logic [31:0] d);
    logic sat;
    int g, b;
    if (s[3]) begin
      g = s[2] ? (bs() ? 1 : 2) : 0;
      if (g == 2 && !s[1] && c_has3) return 1'b0;
      m_ap[g][s[1:0]] = d;
      return 1'b1;
    end
    case (s)
      4'd0: begin
        if (nsv()) begin
          if (!m_pmr[7]) return 1'b0;
          m_pmr = {1'b1, d[7:1]};
        end else m_pmr = d[7:0];
        return 1'b1;
      end
      4'd1: begin m_bp[0] = d[2:0]; return 1'b1; end
      4'd2: begin
        g = bp1_grp(sat);
        if (sat) return 1'b0;
        m_bp[g] = d[2:0];
        return 1'b1;
      end
      4'd3: begin
        b = bs() ? 0 : 1;
        m_eoi[b] = d[1];
        if (!c_has3 || c_sdis) m_cbpr[b] = d[0];
        return 1'b1;
      end
      4'd5: begin m_en[0] = d[0]; return 1'b1; end
      4'd6: begin m_en[bs() ? 1 : 2] = d[0]; return 1'b1; end
      4'd7: begin m_en[2] = d[0]; m_en[1] = d[1]; return 1'b1; end
      default: return 1'b0;
    endcase
  endfunction

  task automatic model_reset();
    m_pmr = '0;
    m_bp[0] = 3'd0; m_bp[1] = 3'd0; m_bp[2] = c_has3 ? 3'd1 : 3'd0;
    for (int g = 0; g < 3; g++) begin
      m_en[g] = 1'b0;
      for (int w = 0; w < 4; w++) m_ap[g][w] = '0;
    end
    for (int b = 0; b < 2; b++) begin m_cbpr[b] = 1'b0; m_eoi[b] = 1'b0; end
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_ctx(logic s, logic [1:0] el, logic h3, logic mon, logic fq, logic sd);
    @(negedge clk);
    c_sec = s; c_el = el; c_has3 = h3; c_mon = mon; c_fiq = fq; c_sdis = sd;
  endtask

  task automatic bus(logic w, logic [3:0] s, logic [31:0] d);
    @(negedge clk);
    valid = 1'b1; write = w; sel = s; wdata = d;
    @(posedge clk);
    #1;
    valid = 1'b0; write = 1'b0;
  endtask

  task automatic wr_chk(string req, logic [3:0] s, logic [31:0] d);
    logic e;
    e = m_write(s, d);
    bus(1'b1, s, d);
    chk(req, {31'h0, update}, {31'h0, e});
  endtask

  task automatic rd_chk(string req, logic [3:0] s);
    logic [31:0] e;
    e = m_read(s);
    bus(1'b0, s, 32'h0);
    chk(req, rdata, e);
    chk("R12", {31'h0, update}, 32'h0);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] held;
    void'($urandom(32'd4242));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1 chk("R1", {31'h0, update}, 32'h0);

    // R1 reset values, secure-banked context
    bus(1'b0, 4'd0, 0);  chk("R1", rdata, 32'h0);
    bus(1'b0, 4'd3, 0);  chk("R1", rdata, 32'h8F00);
    bus(1'b0, 4'd2, 0);  chk("R1", rdata, 32'd0);
    bus(1'b0, 4'd14, 0); chk("R1", rdata, 32'h0);
    set_ctx(0, 2'd1, 1, 0, 0, 0);
    bus(1'b0, 4'd2, 0);  chk("R1", rdata, 32'd1);
    bus(1'b0, 4'd3, 0);  chk("R1", rdata, 32'h8F00);

    // R2 / R3 / R4 priority mask
    set_ctx(1, 2'd1, 1, 0, 0, 0);
    wr_chk("R2", 4'd0, 32'h40); rd_chk("R2", 4'd0);
    chk("R2", rdata, 32'h40);
    set_ctx(0, 2'd1, 1, 0, 1, 0);
    rd_chk("R3", 4'd0); chk("R3", rdata, 32'h0);
    wr_chk("R4", 4'd0, 32'h77); chk("R4", {31'h0, update}, 32'h0);
    set_ctx(1, 2'd1, 1, 0, 1, 0);
    wr_chk("R2", 4'd0, 32'hA5);
    set_ctx(0, 2'd1, 1, 0, 1, 0);
    rd_chk("R3", 4'd0); chk("R3", rdata, 32'h4A);
    set_ctx(1, 2'd1, 1, 0, 1, 0);
    wr_chk("R2", 4'd0, 32'hFF);
    set_ctx(0, 2'd1, 1, 0, 1, 0);
    rd_chk("R3", 4'd0); chk("R3", rdata, 32'hFF);
    wr_chk("R4", 4'd0, 32'h33); chk("R4", {31'h0, update}, 32'h1);
    set_ctx(1, 2'd1, 1, 0, 1, 0);
    rd_chk("R4", 4'd0); chk("R4", rdata, 32'h99);

    // R5 / R6 binary points with secure common-bp
    wr_chk("R5", 4'd1, 32'h5);
    wr_chk("R5", 4'd2, 32'hA);
    rd_chk("R5", 4'd2); chk("R5", rdata, 32'd2);
    set_ctx(1, 2'd1, 1, 0, 0, 1);
    wr_chk("R10", 4'd3, 32'h1);
    rd_chk("R6", 4'd2); chk("R6", rdata, 32'd5);
    set_ctx(1, 2'd1, 1, 1, 0, 1);
    rd_chk("R6", 4'd2); chk("R6", rdata, 32'd2);
    set_ctx(1, 2'd1, 1, 0, 0, 1);
    wr_chk("R6", 4'd2, 32'h6);
    rd_chk("R6", 4'd1); chk("R6", rdata, 32'd6);

    // R10 / R7 non-secure control and common-bp
    set_ctx(0, 2'd1, 1, 0, 0, 0);
    wr_chk("R10", 4'd3, 32'hFFFF_FFFF);
    rd_chk("R10", 4'd3); chk("R10", rdata, 32'h8F02);
    set_ctx(0, 2'd1, 1, 0, 0, 1);
    wr_chk("R10", 4'd3, 32'h1);
    rd_chk("R10", 4'd3); chk("R10", rdata, 32'h8F01);
    rd_chk("R7", 4'd2); chk("R7", rdata, 32'd7);
    wr_chk("R7", 4'd2, 32'h2); chk("R7", {31'h0, update}, 32'h0);
    set_ctx(1, 2'd1, 1, 1, 0, 1);
    wr_chk("R5", 4'd1, 32'h3);
    set_ctx(0, 2'd1, 1, 0, 0, 1);
    rd_chk("R7", 4'd2); chk("R7", rdata, 32'd4);
    set_ctx(0, 2'd3, 1, 0, 0, 1);
    rd_chk("R5", 4'd2); chk("R5", rdata, 32'd1);

    // R8 active-priority words
    set_ctx(1, 2'd1, 1, 0, 0, 0);
    wr_chk("R8", 4'd12, 32'hDEAD_BEEF);
    set_ctx(0, 2'd1, 1, 0, 0, 0);
    wr_chk("R8", 4'd12, 32'h1234); chk("R8", {31'h0, update}, 32'h0);
    wr_chk("R8", 4'd14, 32'hCAFE_F00D);
    rd_chk("R8", 4'd14); chk("R8", rdata, 32'hCAFE_F00D);
    rd_chk("R8", 4'd12); chk("R8", rdata, 32'h0);
    set_ctx(1, 2'd1, 1, 0, 0, 0);
    rd_chk("R8", 4'd12); chk("R8", rdata, 32'hDEAD_BEEF);
    rd_chk("R8", 4'd14);
    set_ctx(0, 2'd1, 0, 0, 0, 0);
    wr_chk("R8", 4'd13, 32'h5555_AAAA); chk("R8", {31'h0, update}, 32'h1);
    wr_chk("R8", 4'd11, 32'h0F0F_0F0F); rd_chk("R8", 4'd11);

    // R9 enables and alias
    set_ctx(1, 2'd1, 1, 0, 0, 0);
    wr_chk("R9", 4'd7, 32'h2);
    rd_chk("R9", 4'd6); chk("R9", rdata, 32'h1);
    set_ctx(0, 2'd1, 1, 0, 0, 0);
    rd_chk("R9", 4'd6); chk("R9", rdata, 32'h0);
    wr_chk("R9", 4'd6, 32'h1);
    rd_chk("R9", 4'd7); chk("R9", rdata, 32'h3);
    wr_chk("R9", 4'd5, 32'h1); rd_chk("R9", 4'd5);

    // R11 hold, R12 unused select
    rd_chk("R11", 4'd7);
    held = rdata;
    @(negedge clk); @(posedge clk); #1;
    chk("R11", rdata, held);
    wr_chk("R12", 4'd4, 32'hFFFF_FFFF); chk("R12", {31'h0, update}, 32'h0);
    chk("R11", rdata, held);
    rd_chk("R11", 4'd4);

    // random phase
    for (int i = 0; i < 600; i++) begin
      logic [3:0] rs;
      logic [31:0] rdv;
      rdv = $urandom;
      set_ctx(1'($urandom), 2'($urandom), 1'($urandom_range(0, 3) != 0),
              1'($urandom), 1'($urandom), 1'($urandom));
      rs = 4'($urandom);
      if ($urandom_range(0, 1) == 1) wr_chk("R12 rand", rs, rdv);
      else                           rd_chk("R5 rand", rs);
    end

    finish_run();
  end
endmodule